// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo PCM bit stream into parallel sample pairs. It takes a bit clock, a left/right framing clock and a serial data line, and it runs on a faster system clock. It synchronises the three lines, finds the rising edges of the bit clock, and samples the framing clock and the data on those edges. Once per frame it presents a left and right sample together, with a one-cycle strobe.

A static format select input chooses how a word sits inside each half-frame:
- I2S with an 18-bit word at 64 bit clocks per frame.
- I2S with a 16-bit word at 32 bit clocks per frame.
- MSB-first left-justified with a 16-bit word.
- Right-justified with a 16-bit or an 18-bit word.

In every format data arrives MSB first, and the framing clock low marks the left channel. A framing edge that arrives while a word is still being collected throws that word away, and reception restarts from that edge.

Top module: `pcm_rx`

## Requirements
- R1: While `rstN` is low, and until the first sample pair is delivered, `leftOut` and `rightOut` are zero and `sampleValid` is low.
- R2: Serial data and the framing clock are sampled on rising bit clock edges only, and each word is received MSB first.
- R3: With `fmtSel` = 0 (I2S, 18-bit, 32 bit clocks per half-frame), the MSB is the bit sampled one bit clock after a framing edge. Framing clock low marks the left channel, which comes first in the frame.
- R4: With `fmtSel` = 1 (I2S, 16-bit, 16 bit clocks per half-frame), the MSB arrives one bit clock after a framing edge. The LSB is the bit sampled on the first bit clock after the next framing edge.
- R5: With `fmtSel` = 2 (left-justified, 16-bit), the MSB is the bit sampled on the first bit clock of a half-frame, and the bits after the LSB are ignored.
- R6: With `fmtSel` = 3 (16-bit) or `fmtSel` = 4 (18-bit), words are right-justified. The LSB is the bit sampled on the 32nd bit clock of the half-frame, and the bits before the MSB are ignored.
- R7: Output samples are 18 bits wide with the MSB in bit 17. A 16-bit word fills bits 17..2, and bits 1..0 are zero.
- R8: `sampleValid` is high for exactly one system clock after each completed right-channel word that follows a completed left-channel word. At that cycle both channels are presented together, and `leftOut` and `rightOut` change only on a `sampleValid` cycle.
- R9: A framing edge that arrives before the current word is complete discards that word, except for the I2S LSB that falls on the edge bit. No sample pair is produced for that frame, and reception resumes from that edge.
- R10: `fmtSel` values 5, 6 and 7 start no word and produce no sample pair, and the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitClkIn | input | 1 | Serial bit clock, asynchronous to `clk` |
| lrClkIn | input | 1 | Left/right framing clock, low for the left channel |
| dataIn | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 3 | Frame format: 0 I2S-18, 1 I2S-16 at 32fs, 2 left-justified 16, 3 right-justified 16, 4 right-justified 18 |
| leftOut | output | 18 | Left sample, MSB-aligned |
| rightOut | output | 18 | Right sample, MSB-aligned |
| sampleValid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The bound checker checks three properties on every cycle:
- `sampleValid` never lasts longer than one cycle.
- The sample outputs never move except in a strobe cycle.
- A strobe in a 16-bit format always carries zero padding in the two low bits.

Only the directed scenarios can show that the bit positions are right for each format, because that needs known words placed in streams whose unused bits are ones. The same applies to discarding a word cut short by an early framing edge, to the silence under an unused format code, and to the I2S word whose LSB crosses into the next half-frame.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S18 = 3'd0,
    FMT_I2S16 = 3'd1,
    FMT_LJ16  = 3'd2,
    FMT_RJ16  = 3'd3,
    FMT_RJ18  = 3'd4
  } fmt_e;

  // Strobes from control to datapath, all valid in one system clock cycle
  typedef struct packed {
    logic shift;      // take dataBit into the word register
    logic clear;      // dataBit is the MSB of a new word
    logic dataBit;    // synchronised serial bit at this bit clock edge
    logic wide;       // word being finished is full width
    logic latchLeft;  // finished word is the left channel
    logic emitPair;   // finished word is the right channel of a full pair
  } dpCtl_t;

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int NARROW_W  = 16,
  parameter int HALF_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClkS,
  input  logic       lrClkS,
  input  logic       dataS,
  input  logic [2:0] fmtSel,
  output dpCtl_t     ctl
);

  localparam int IDX_W = $clog2(2 * HALF_BITS);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             bitClkPrev;
  logic             lrLast, lrRef, lrLocked;
  logic [IDX_W-1:0] idx, curIdx, startIdx;
  logic             active, wordChan, wordWide, leftHave;
  logic [CNT_W-1:0] remain, wordLen;
  logic             fmtOk, isI2s;
  logic             bitRise, lrEdge, dropWord, startNow, finishNow;

  assign bitRise = bitClkS & ~bitClkPrev;
  assign lrEdge  = bitRise && lrRef && (lrClkS != lrLast);
  assign curIdx  = lrEdge ? '0 : idx;

  always_comb begin
    fmtOk    = 1'b1;
    isI2s    = 1'b0;
    startIdx = '0;
    wordLen  = CNT_W'(NARROW_W);
    case (fmtSel)
      FMT_I2S18: begin isI2s = 1'b1; startIdx = IDX_W'(1); wordLen = CNT_W'(WORD_W); end
      FMT_I2S16: begin isI2s = 1'b1; startIdx = IDX_W'(1); end
      FMT_LJ16:  startIdx = '0;
      FMT_RJ16:  startIdx = IDX_W'(HALF_BITS - NARROW_W);
      FMT_RJ18:  begin startIdx = IDX_W'(HALF_BITS - WORD_W); wordLen = CNT_W'(WORD_W); end
      default:   fmtOk = 1'b0;
    endcase
  end

  // An I2S LSB may land on the edge bit; anything else still open is cut short
  assign dropWord  = lrEdge && active && !(isI2s && remain == CNT_W'(1));
  assign startNow  = bitRise && (lrLocked || lrEdge) && fmtOk && (curIdx == startIdx);
  assign finishNow = bitRise && active && !dropWord && !startNow && (remain == CNT_W'(1));

  always_comb begin
    ctl           = '0;
    ctl.dataBit   = dataS;
    ctl.wide      = wordWide;
    ctl.clear     = startNow;
    ctl.shift     = bitRise && (startNow || (active && !dropWord));
    ctl.latchLeft = finishNow && !wordChan;
    ctl.emitPair  = finishNow && wordChan && leftHave;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkPrev <= 1'b0;
      lrLast     <= 1'b0;
      lrRef      <= 1'b0;
      lrLocked   <= 1'b0;
      idx        <= '0;
      active     <= 1'b0;
      remain     <= '0;
      wordChan   <= 1'b0;
      wordWide   <= 1'b0;
      leftHave   <= 1'b0;
    end else begin
      bitClkPrev <= bitClkS;
      if (bitRise) begin
        lrLast <= lrClkS;
        lrRef  <= 1'b1;
        if (lrEdge) lrLocked <= 1'b1;
        if (lrEdge)              idx <= IDX_W'(1);
        else if (idx != IDX_MAX) idx <= idx + 1'b1;

        if (startNow) begin
          active   <= 1'b1;
          remain   <= wordLen - 1'b1;
          wordChan <= lrClkS;
          wordWide <= (wordLen == CNT_W'(WORD_W));
        end else if (finishNow || dropWord) begin
          active <= 1'b0;
        end else if (active) begin
          remain <= remain - 1'b1;
        end

        if (finishNow && !wordChan)                     leftHave <= 1'b1;
        else if (dropWord || (finishNow && wordChan))   leftHave <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcm_rx_dp.sv
module pcm_rx_dp
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W   = 18,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleValid
);

  localparam int PAD_W = WORD_W - NARROW_W;

  logic [WORD_W-1:0] wordReg, shifted, aligned, leftHold;

  assign shifted = {wordReg[WORD_W-2:0], ctl.dataBit};

  generate
    if (PAD_W > 0) begin : g_pad
      assign aligned = ctl.wide ? shifted : {shifted[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign aligned = shifted;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg     <= '0;
      leftHold    <= '0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (ctl.shift) wordReg <= ctl.clear ? {{(WORD_W-1){1'b0}}, ctl.dataBit} : shifted;
      if (ctl.latchLeft) leftHold <= aligned;
      if (ctl.emitPair) begin
        leftOut  <= leftHold;
        rightOut <= aligned;
      end
      sampleValid <= ctl.emitPair;
    end
  end

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int NARROW_W    = 16,
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClkIn,
  input  logic              lrClkIn,
  input  logic              dataIn,
  input  logic [2:0]        fmtSel,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleValid
);

  logic [2:0] syncOut;
  dpCtl_t     ctl;

  pcm_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bitClkIn, lrClkIn, dataIn}),
    .dout (syncOut)
  );

  pcm_rx_ctrl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .HALF_BITS(HALF_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitClkS (syncOut[2]),
    .lrClkS  (syncOut[1]),
    .dataS   (syncOut[0]),
    .fmtSel  (fmtSel),
    .ctl     (ctl)
  );

  pcm_rx_dp #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .leftOut     (leftOut),
    .rightOut    (rightOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        fmtSel,
  input logic [WORD_W-1:0] leftOut,
  input logic [WORD_W-1:0] rightOut,
  input logic              sampleValid
);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8
  left_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(leftOut) |-> sampleValid);

  // R8
  right_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rightOut) |-> sampleValid);

  // R7
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (fmtSel == 3'd1 || fmtSel == 3'd2 || fmtSel == 3'd3))
      |-> (leftOut[1:0] == 2'b00 && rightOut[1:0] == 2'b00));

endmodule

bind pcm_rx pcm_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .fmtSel      (fmtSel),
  .leftOut     (leftOut),
  .rightOut    (rightOut),
  .sampleValid (sampleValid)
);

// File: tb/pcm_rx_test.sv
`timescale 1ns/1ps
module pcm_rx_test;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        bitClk = 1'b0, lrClk = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [17:0] leftOut, rightOut;
  logic        sampleValid;

  always #2.5 clk = ~clk;

  pcm_rx uut (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClk), .lrClkIn(lrClk), .dataIn(sdata),
    .fmtSel(fmt), .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

  int vecs = 0, miss = 0, pulseErr = 0;
  logic [17:0] gotL[$], gotR[$];
  logic [17:0] expL[8], expR[8];
  logic prevV = 1'b0;

  always @(negedge clk) begin
    if (sampleValid) begin
      gotL.push_back(leftOut);
      gotR.push_back(rightOut);
      if (prevV) pulseErr++;
    end
    prevV = sampleValid;
  end

  logic sLr[0:2047], sD[0:2047];
  int   sLen = 0;
  logic carryOn = 1'b0, carryBit = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Unused bit positions are filled with ones so ignored bits are visible
  task automatic addHalf(input logic ch, input logic [17:0] w, input int wl, input int st, input int hl);
    int base = sLen;
    for (int i = 0; i < hl; i++) begin sLr[base+i] = ch; sD[base+i] = 1'b1; end
    if (carryOn) begin sD[base] = carryBit; carryOn = 1'b0; end
    for (int k = 0; k < wl; k++) begin
      int p = st + k;
      if (p < hl) sD[base+p] = w[wl-1-k];
      else begin carryOn = 1'b1; carryBit = w[wl-1-k]; end
    end
    sLen = base + hl;
  endtask

  task automatic play();
    for (int i = 0; i < sLen; i++) begin
      @(posedge clk); #1;
      bitClk = 1'b0; lrClk = sLr[i]; sdata = sD[i];
      repeat (4) @(posedge clk);
      #1 bitClk = 1'b1;
      repeat (3) @(posedge clk);
    end
    sLen = 0;
    repeat (30) @(posedge clk);
  endtask

  // Lead right half (junk), n frames, short left trailer carrying any I2S LSB
  task automatic buildFrames(input int n, input int hl, input int wl, input int st);
    logic [17:0] mask = (wl == 18) ? 18'h3FFFF : 18'h0FFFF;
    addHalf(1'b1, 18'h0, 0, 0, hl);
    for (int f = 0; f < n; f++) begin
      logic [17:0] l = 18'($urandom) & mask;
      logic [17:0] r = 18'($urandom) & mask;
      if (f == 0) begin l = mask; r = 18'h1 & mask; end
      addHalf(1'b0, l, wl, st, hl);
      addHalf(1'b1, r, wl, st, hl);
      expL[f] = (wl == 18) ? l : {l[15:0], 2'b00};
      expR[f] = (wl == 18) ? r : {r[15:0], 2'b00};
    end
    addHalf(1'b0, 18'h0, 0, 0, 2);
  endtask

  task automatic verify(input int n, input string req);
    check(gotL.size() == n, {req, " pair count"}, gotL.size(), n);
    for (int f = 0; f < n && f < gotL.size(); f++) begin
      check(gotL[f] == expL[f], {req, " left"}, gotL[f], expL[f]);
      check(gotR[f] == expR[f], {req, " right"}, gotR[f], expR[f]);
    end
    check(pulseErr == 0, "R8 strobe width", pulseErr, 0);
    gotL.delete(); gotR.delete();
  endtask

  task automatic testReset();
    check(leftOut == 18'h0 && rightOut == 18'h0, "R1 outputs zero", {leftOut[15:0], rightOut[15:0]}, 0);
    check(sampleValid == 1'b0, "R1 strobe low", sampleValid, 0);
  endtask

  task automatic testI2s18();   // R3, R2
    fmt = 3'd0; buildFrames(3, 32, 18, 1); play(); verify(3, "R3");
  endtask

  task automatic testI2s16();   // R4
    fmt = 3'd1; buildFrames(3, 16, 16, 1); play(); verify(3, "R4");
  endtask

  task automatic testLeftJust(); // R5, R7
    fmt = 3'd2; buildFrames(3, 32, 16, 0); play(); verify(3, "R5");
  endtask

  task automatic testRight16(); // R6
    fmt = 3'd3; buildFrames(3, 32, 16, 16); play(); verify(3, "R6 rj16");
  endtask

  task automatic testRight18(); // R6
    fmt = 3'd4; buildFrames(2, 32, 18, 14); play(); verify(2, "R6 rj18");
  endtask

  task automatic testEarlyEdge(); // R9
    fmt = 3'd2;
    addHalf(1'b1, 18'h0, 0, 0, 32);
    addHalf(1'b0, 18'h0, 0, 0, 8);            // left cut short after 8 bits
    addHalf(1'b1, 18'h0ABCD, 16, 0, 32);      // right alone: no pair
    addHalf(1'b0, 18'h01234, 16, 0, 32);
    addHalf(1'b1, 18'h0FEDC, 16, 0, 32);
    addHalf(1'b0, 18'h0, 0, 0, 2);
    expL[0] = {16'h1234, 2'b00};
    expR[0] = {16'hFEDC, 2'b00};
    play(); verify(1, "R9");
  endtask

  task automatic testBadFmt();  // R10
    logic [17:0] holdL = leftOut, holdR = rightOut;
    fmt = 3'd7; buildFrames(2, 32, 16, 0); play();
    check(gotL.size() == 0, "R10 no pairs", gotL.size(), 0);
    check(leftOut == holdL && rightOut == holdR, "R10 outputs kept", leftOut, holdL);
    gotL.delete(); gotR.delete();
  endtask

  initial begin
    #750000;
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 testReset();
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    #1 testReset();
    testI2s18();
    testI2s16();
    testLeftJust();
    testRight16();
    testRight18();
    testEarlyEdge();
    testBadFmt();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule